// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands of `WIDTH` bits (32 by default) and returns their full product of twice that width. It trades speed for area. A single `WIDTH`-bit adder and one double-width product register do all the work, and one multiplier bit is retired per clock.

A request is made by raising `start` for one cycle while `busy` is low. The operands are captured on that edge, so the driver may change them afterwards. `busy` then stays high for exactly `WIDTH` cycles. In the cycle after the last step, `done` pulses high for one cycle and `product` holds the result. The result stays on `product` until the next request is accepted.

Internally the low half of the product register starts out holding the multiplier. Each step tests the register's least significant bit. When that bit is 1, the adder adds the held multiplicand to the upper half. The register then shifts right by one, with the adder's carry-out entering at the top.

Top module: `shift_add_mult`

## Requirements
- R1: While and after synchronous reset `rst` is applied, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` seen high on a rising edge while `busy` is low is accepted. `busy` is high from the next cycle on. The operand values present on that edge are used, and later changes on the operand inputs have no effect on the result.
- R3: For every pair of unsigned operands, `product` equals multiplicand × multiplier as an unsigned `2*WIDTH`-bit number while `done` is high.
- R4: `done` is high for exactly one cycle per accepted request, in the cycle right after `busy` falls. `busy` is 0 whenever `done` is 1.
- R5: `start` is ignored while `busy` is high. Neither the result nor the completion cycle of the running request changes.
- R6: After completion, `product` keeps its value in every later cycle until a new request is accepted.
- R7: The adder carry-out is kept, so the largest operands give the exact product; with `WIDTH` = 4, 15 × 15 gives 225.
- R8: With `WIDTH` = 4, 2 × 6 gives 12.
- R9: `busy` stays high for exactly `WIDTH` consecutive cycles per accepted request, one per multiplier bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse, accepted only while not busy |
| multiplicand | input | WIDTH | First operand, unsigned |
| multiplier | input | WIDTH | Second operand, unsigned |
| busy | output | 1 | High while the shift-add steps run |
| done | output | 1 | One-cycle pulse marking a valid product |
| product | output | 2*WIDTH | Product register contents; the result once done |

## Verification
An accepted `start` on edge E0 makes `busy` visible from E0 onward. The `WIDTH` steps then run on edges E1 through E`WIDTH`, so `done` and the result appear after edge E`WIDTH` and `done` clears one edge later. The bench drives on falling edges and samples on falling edges. Right after E0 it checks `busy`, at every following falling edge up to the last step it checks that `busy` is still high and `done` is still low, then it checks the result and the `done` pulse at the falling edge after E`WIDTH`. One edge later it checks that `done` is gone and the product is unchanged. All pairs of 4-bit operands are swept this way, with extra start pulses and changed operand inputs applied during the run.

// File: rtl/shm_pkg.sv
package shm_pkg;

    // Default operand width of the multiplier.
    localparam int unsigned SHM_DEF_WIDTH = 32;

    // Sequencer states.
    typedef enum logic {
        SHM_IDLE = 1'b0,
        SHM_RUN  = 1'b1
    } shm_state_e;

    // Width of a down-counter that must hold the value n.
    function automatic int unsigned shm_cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/shm_adder.sv
// Narrow adder: adds an addend (gated by enable) to the upper half,
// returning WIDTH+1 bits so the carry-out is preserved.
module shm_adder #(
    parameter int unsigned WIDTH = shm_pkg::SHM_DEF_WIDTH
) (
    input  logic [WIDTH-1:0] upper,
    input  logic [WIDTH-1:0] addend,
    input  logic             enable,
    output logic [WIDTH:0]   sum
);
    logic [WIDTH-1:0] gated;

    always_comb begin
        gated = enable ? addend : '0;
        sum   = {1'b0, upper} + {1'b0, gated};
    end
endmodule

// File: rtl/shm_ctrl.sv
// Sequencer: accepts a request, counts WIDTH steps, emits done.
module shm_ctrl
    import shm_pkg::*;
#(
    parameter int unsigned WIDTH = SHM_DEF_WIDTH
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int unsigned CW = shm_cnt_bits(WIDTH);

    shm_state_e    state_q;
    logic [CW-1:0] left_q;
    logic          done_q;

    always_comb begin
        load = (state_q == SHM_IDLE) && start;
        step = (state_q == SHM_RUN);
        busy = (state_q == SHM_RUN);
        done = done_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SHM_IDLE;
            left_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                SHM_IDLE: begin
                    if (start) begin
                        state_q <= SHM_RUN;
                        left_q  <= CW'(WIDTH);
                    end
                end
                SHM_RUN: begin
                    left_q <= left_q - CW'(1);
                    if (left_q == CW'(1)) begin
                        state_q <= SHM_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= SHM_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/shm_datapath.sv
// Multiplicand register plus one double-width product register whose
// low half initially holds the multiplier and is consumed by shifting.
module shm_datapath #(
    parameter int unsigned WIDTH = shm_pkg::SHM_DEF_WIDTH
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               step,
    input  logic [WIDTH-1:0]   mcand_in,
    input  logic [WIDTH-1:0]   mplier_in,
    output logic [2*WIDTH-1:0] product
);
    localparam int unsigned PW = 2 * WIDTH;

    logic [WIDTH-1:0] mcand_q;
    logic [PW-1:0]    prod_q;
    logic [WIDTH:0]   sum;
    logic [PW-1:0]    prod_next;

    shm_adder #(.WIDTH(WIDTH)) u_adder (
        .upper  (prod_q[PW-1:WIDTH]),
        .addend (mcand_q),
        .enable (prod_q[0]),
        .sum    (sum)
    );

    // Shift right by one with the carry-out taking the top bit.
    generate
        if (WIDTH > 1) begin : g_wide
            always_comb prod_next = {sum, prod_q[WIDTH-1:1]};
        end else begin : g_single
            always_comb prod_next = sum;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            prod_q  <= '0;
        end else if (load) begin
            mcand_q <= mcand_in;
            prod_q  <= {{WIDTH{1'b0}}, mplier_in};
        end else if (step) begin
            prod_q  <= prod_next;
        end
    end

    assign product = prod_q;
endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult
    import shm_pkg::*;
#(
    parameter int unsigned WIDTH = SHM_DEF_WIDTH
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [WIDTH-1:0]   multiplicand,
    input  logic [WIDTH-1:0]   multiplier,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);
    logic load;
    logic step;

    shm_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    shm_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .step      (step),
        .mcand_in  (multiplicand),
        .mplier_in (multiplier),
        .product   (product)
    );
endmodule

// File: rtl/shift_add_mult_chk.sv
module shift_add_mult_chk #(
    parameter int unsigned WIDTH = shm_pkg::SHM_DEF_WIDTH
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [WIDTH-1:0]   multiplicand,
    input logic [WIDTH-1:0]   multiplier,
    input logic               busy,
    input logic               done,
    input logic [2*WIDTH-1:0] product
);
    localparam int unsigned PW = 2 * WIDTH;
    localparam int unsigned CB = shm_pkg::shm_cnt_bits(WIDTH) + 1;

    logic [WIDTH-1:0] cap_a;
    logic [WIDTH-1:0] cap_b;
    logic [CB-1:0]    busy_run;
    logic             busy_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_a    <= '0;
            cap_b    <= '0;
            busy_run <= '0;
            busy_d   <= 1'b0;
        end else begin
            busy_d <= busy;
            if (start && !busy) begin
                cap_a <= multiplicand;
                cap_b <= multiplier;
            end
            busy_run <= busy ? busy_run + CB'(1) : '0;
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk) rst |=> (!busy && !done && product == '0));
    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy);
    a_r3_product_ok: assert property (@(posedge clk) disable iff (rst)
        done |-> (product == (PW'(cap_a) * PW'(cap_b))));
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    a_r4_done_idle:  assert property (@(posedge clk) disable iff (rst) done |-> !busy);
    a_r4_done_after: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);
    a_r6_hold:       assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));
    a_r9_run_length: assert property (@(posedge clk) disable iff (rst)
        (busy_d && !busy) |-> (busy_run == CB'(WIDTH)));
endmodule

bind shift_add_mult shift_add_mult_chk #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .busy         (busy),
    .done         (done),
    .product      (product)
);

// File: tb/shift_add_mult_bench.sv
`timescale 1ns/1ps
module shift_add_mult_bench;
    localparam int W  = 4;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [W-1:0]  mc;
    logic [W-1:0]  mp;
    logic          busy;
    logic          done;
    logic [PW-1:0] product;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    shift_add_mult #(.WIDTH(W)) u_shift_add_mult (
        .clk(clk), .rst(rst), .start(start),
        .multiplicand(mc), .multiplier(mp),
        .busy(busy), .done(done), .product(product)
    );

    task automatic chk(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One request: start accepted on the next rising edge; sampling on falling edges.
    task automatic run(input int a, input int b, input bit disturb, input string tag);
        logic [PW-1:0] exp;
        exp = PW'(a * b);
        @(negedge clk);
        mc = W'(a); mp = W'(b); start = 1'b1;
        @(negedge clk);                       // after accept edge E0
        start = 1'b0;
        chk("R2 busy after start", PW'(busy), PW'(1));
        mc = ~W'(a); mp = W'(b + 5);          // R2: late operand changes ignored
        for (int k = 1; k <= W; k++) begin
            if (disturb) start = (k % 2 == 1); // R5: start during busy ignored
            @(negedge clk);                    // after edge Ek
            start = 1'b0;
            if (k < W) begin
                chk("R9 busy during steps", PW'(busy), PW'(1));
                chk("R4 no early done", PW'(done), PW'(0));
            end
        end
        chk({tag, " product"}, product, exp);
        chk("R4 done high", PW'(done), PW'(1));
        chk("R4 busy low with done", PW'(busy), PW'(0));
        @(negedge clk);
        chk("R4 done one cycle", PW'(done), PW'(0));
        chk("R6 product held", product, exp);
        @(negedge clk);
        chk("R6 product still held", product, exp);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; mc = '0; mp = '0;
        repeat (3) @(negedge clk);
        chk("R1 busy reset", PW'(busy), PW'(0));
        chk("R1 done reset", PW'(done), PW'(0));
        chk("R1 product reset", product, '0);
        rst = 1'b0;
        run(15, 15, 1'b0, "R7 carry 15x15");
        run(2, 6, 1'b0, "R8 2x6");
        run(15, 15, 1'b1, "R5 start ignored 15x15");
        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                run(a, b, ((a + b) % 3 == 0), "R3 sweep");
            end
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_900_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule